// File: doc/BRIEF.md
# Parallel-Snapshot Serial Frame Controller

This block sits in front of a serial master's shifter and decides when a serialization frame begins and what it carries. The data comes from one of two registers. One holds a snapshot of parallel input pins, taken when a latch strobe is pulsed. The other holds an alternate word written by the host. A source-select input chooses between the two.

A frame request (`trigger`) normally starts a frame one cycle later. With change detection enabled, a request starts a frame only if the selected word differs from the word carried by the last frame that actually started. The block also works out the effective frame length from a base size field plus two extension bits. It drives a keep-chip-select-asserted flag, and it raises a configuration error when two mutually exclusive options are both enabled.

The shift register and the baud generator lie outside this block. They consume `frameStart`, `frameData`, `frameLen` and `csHold`.

Top module: `snapshot_frame_ctrl`

## Requirements
- R1: A pulse on `pinLatch` copies `pinIn` into the snapshot register, and a pulse on `altWrEn` copies `altWrData` into the alternate register. A write becomes visible to frame selection from the following cycle.
- R2: `srcSel` = 0 selects the snapshot register and `srcSel` = 1 selects the alternate register. The selected word is captured into `frameData` when a frame starts and is held unchanged until the next start.
- R3: With `chgDetEn` = 0, `trigger` high in cycle N gives a one-cycle `frameStart` pulse in cycle N+1. There is never a `frameStart` without a `trigger` in the previous cycle.
- R4: With `chgDetEn` = 1, a trigger starts a frame only if the selected word differs from the word of the last started frame. The first trigger after reset always starts a frame.
- R5: The record of the last frame's word updates only when a frame starts. Words latched or written in between, without a start, do not affect later comparisons.
- R6: At each start, `frameLen` = base + 1 + 16·`ext4` + 32·(`ext5` AND `mode64En`). Here base is the 4-bit `baseSize` field, so the range is 1 to 64. The value is held until the next start.
- R7: `ext5` has no effect on `frameLen` while `mode64En` = 0, so the length never exceeds 32 in that state.
- R8: `csHold` equals `contCsEn` AND NOT `tsbEn` of the previous cycle. Continuous chip-select has no effect in timed-serial-bus configuration.
- R9: `cfgErr` is high in cycle N+1 exactly when `chgDetEn` and `contCsEn` are both high in cycle N.
- R10: After reset, `frameStart`, `frameData`, `frameLen`, `csHold` and `cfgErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Frame request |
| pinIn | input | DATA_W | Parallel input pins |
| pinLatch | input | 1 | Snapshot strobe for pinIn |
| altWrEn | input | 1 | Host write strobe for the alternate word |
| altWrData | input | DATA_W | Host alternate word |
| srcSel | input | 1 | 0 snapshot, 1 alternate |
| chgDetEn | input | 1 | Start only on changed data |
| contCsEn | input | 1 | Keep chip selects asserted between frames |
| tsbEn | input | 1 | Timed-serial-bus configuration |
| mode64En | input | 1 | Enables the 32-bit extension |
| baseSize | input | BASE_W | Frame size minus one |
| ext4 | input | 1 | Adds 16 to the frame size |
| ext5 | input | 1 | Adds 32 to the frame size in 64-bit mode |
| frameStart | output | 1 | One-cycle frame start strobe |
| frameData | output | DATA_W | Word for the current frame |
| frameLen | output | BASE_W+3 | Effective frame length in bits |
| csHold | output | 1 | Keep chip selects asserted |
| cfgErr | output | 1 | Conflicting configuration flag |

## Verification
The bench builds the block with DATA_W = 8 and BASE_W = 4. The narrow data word lets random pin and host values, drawn from a four-value set, repeat often. That makes both outcomes of change detection (suppressed and started) frequent. The 4-bit base keeps the full 1 to 64 length range and every extension combination reachable, including `ext5` set with 64-bit mode off.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef struct packed {
    logic startFrame;
    logic checkChange;
  } sfcStrobes_t;
endpackage

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE_W = 4,
  localparam int LEN_W = BASE_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pinIn,
  input  logic              pinLatch,
  input  logic              altWrEn,
  input  logic [DATA_W-1:0] altWrData,
  input  logic              srcSel,
  input  logic [BASE_W-1:0] baseSize,
  input  logic              ext4,
  input  logic              ext5,
  input  logic              mode64En,
  input  sfcStrobes_t       strobes,
  output logic              dataDiffers,
  output logic [DATA_W-1:0] frameData,
  output logic [LEN_W-1:0]  frameLen
);
  logic [DATA_W-1:0] snapReg;
  logic [DATA_W-1:0] altReg;
  logic [DATA_W-1:0] prevReg;
  logic              prevValid;
  logic [DATA_W-1:0] selWord;
  logic [LEN_W-1:0]  lenNext;

  always_comb begin
    selWord = srcSel ? altReg : snapReg;
    lenNext = LEN_W'({(ext5 & mode64En), ext4, baseSize}) + LEN_W'(1);
    dataDiffers = strobes.checkChange ? (!prevValid || (selWord != prevReg)) : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapReg   <= '0;
      altReg    <= '0;
      prevReg   <= '0;
      prevValid <= 1'b0;
      frameData <= '0;
      frameLen  <= '0;
    end else begin
      if (pinLatch) snapReg <= pinIn;
      if (altWrEn)  altReg  <= altWrData;
      if (strobes.startFrame) begin
        prevReg   <= selWord;
        prevValid <= 1'b1;
        frameData <= selWord;
        frameLen  <= lenNext;
      end
    end
  end
endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  input  logic        chgDetEn,
  input  logic        contCsEn,
  input  logic        tsbEn,
  input  logic        dataDiffers,
  output sfcStrobes_t strobes,
  output logic        frameStart,
  output logic        csHold,
  output logic        cfgErr
);
  always_comb begin
    strobes.checkChange = chgDetEn;
    strobes.startFrame  = trigger && dataDiffers;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameStart <= 1'b0;
      csHold     <= 1'b0;
      cfgErr     <= 1'b0;
    end else begin
      frameStart <= strobes.startFrame;
      csHold     <= contCsEn && !tsbEn;
      cfgErr     <= chgDetEn && contCsEn;
    end
  end
endmodule

// File: rtl/snapshot_frame_ctrl.sv
module snapshot_frame_ctrl
  import sfc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE_W = 4,
  localparam int LEN_W = BASE_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigger,
  input  logic [DATA_W-1:0] pinIn,
  input  logic              pinLatch,
  input  logic              altWrEn,
  input  logic [DATA_W-1:0] altWrData,
  input  logic              srcSel,
  input  logic              chgDetEn,
  input  logic              contCsEn,
  input  logic              tsbEn,
  input  logic              mode64En,
  input  logic [BASE_W-1:0] baseSize,
  input  logic              ext4,
  input  logic              ext5,
  output logic              frameStart,
  output logic [DATA_W-1:0] frameData,
  output logic [LEN_W-1:0]  frameLen,
  output logic              csHold,
  output logic              cfgErr
);
  sfcStrobes_t strobes;
  logic        dataDiffers;

  sfc_datapath #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinLatch(pinLatch),
    .altWrEn(altWrEn), .altWrData(altWrData), .srcSel(srcSel),
    .baseSize(baseSize), .ext4(ext4), .ext5(ext5), .mode64En(mode64En),
    .strobes(strobes), .dataDiffers(dataDiffers),
    .frameData(frameData), .frameLen(frameLen)
  );

  sfc_control u_control (
    .clk(clk), .rstN(rstN), .trigger(trigger), .chgDetEn(chgDetEn),
    .contCsEn(contCsEn), .tsbEn(tsbEn), .dataDiffers(dataDiffers),
    .strobes(strobes), .frameStart(frameStart), .csHold(csHold),
    .cfgErr(cfgErr)
  );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int DATA_W = 64,
  parameter int BASE_W = 4,
  localparam int LEN_W = BASE_W + 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              trigger,
  input logic              chgDetEn,
  input logic              contCsEn,
  input logic              tsbEn,
  input logic              mode64En,
  input logic [BASE_W-1:0] baseSize,
  input logic              ext4,
  input logic              ext5,
  input logic              frameStart,
  input logic [DATA_W-1:0] frameData,
  input logic [LEN_W-1:0]  frameLen,
  input logic              csHold,
  input logic              cfgErr
);
  logic [DATA_W-1:0] lastData;
  logic              hadFrame;
  logic              pastValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastData  <= '0;
      hadFrame  <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (frameStart) begin
        lastData <= frameData;
        hadFrame <= 1'b1;
      end
    end
  end

  assert_start_needs_trigger_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && frameStart) |-> $past(trigger));

  assert_change_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && frameStart && $past(chgDetEn) && hadFrame) |-> (frameData != lastData));

  assert_data_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !frameStart) |-> $stable(frameData));

  assert_len_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && frameStart) |->
      (frameLen == LEN_W'($past(baseSize)) + LEN_W'(1)
                 + ($past(ext4) ? LEN_W'(1 << BASE_W) : LEN_W'(0))
                 + (($past(ext5) && $past(mode64En)) ? LEN_W'(2 << BASE_W) : LEN_W'(0))));

  assert_ext5_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && frameStart && !$past(mode64En)) |-> (frameLen <= LEN_W'(2 << BASE_W)));

  assert_cs_tsb_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(tsbEn)) |-> !csHold);

  assert_cfg_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (cfgErr == ($past(chgDetEn) && $past(contCsEn))));
endmodule

bind snapshot_frame_ctrl sfc_checker #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_sfc_checker (
  .clk(clk), .rstN(rstN), .trigger(trigger), .chgDetEn(chgDetEn),
  .contCsEn(contCsEn), .tsbEn(tsbEn), .mode64En(mode64En),
  .baseSize(baseSize), .ext4(ext4), .ext5(ext5), .frameStart(frameStart),
  .frameData(frameData), .frameLen(frameLen), .csHold(csHold), .cfgErr(cfgErr)
);

// File: tb/snapshot_frame_ctrl_tb.sv
module snapshot_frame_ctrl_tb;
  localparam int DW = 8;
  localparam int BW = 4;
  localparam int LW = BW + 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, trigger, pinLatch, altWrEn, srcSel, chgDetEn, contCsEn, tsbEn, mode64En, ext4, ext5;
  logic [DW-1:0] pinIn, altWrData;
  logic [BW-1:0] baseSize;
  logic frameStart, csHold, cfgErr;
  logic [DW-1:0] frameData;
  logic [LW-1:0] frameLen;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  snapshot_frame_ctrl #(.DATA_W(DW), .BASE_W(BW)) u_dut (
    .clk(clk), .rstN(rstN), .trigger(trigger), .pinIn(pinIn), .pinLatch(pinLatch),
    .altWrEn(altWrEn), .altWrData(altWrData), .srcSel(srcSel), .chgDetEn(chgDetEn),
    .contCsEn(contCsEn), .tsbEn(tsbEn), .mode64En(mode64En), .baseSize(baseSize),
    .ext4(ext4), .ext5(ext5), .frameStart(frameStart), .frameData(frameData),
    .frameLen(frameLen), .csHold(csHold), .cfgErr(cfgErr)
  );

  // behavioural reference
  logic [DW-1:0] mSnap, mAlt, mPrev, mSel, eData;
  logic mPrevValid, eStart, eCs, eErr, mGo;
  int eLen;

  always @(posedge clk) begin
    if (!rstN) begin
      mSnap <= '0; mAlt <= '0; mPrev <= '0; mPrevValid <= 1'b0;
      eStart <= 1'b0; eData <= '0; eLen <= 0; eCs <= 1'b0; eErr <= 1'b0;
    end else begin
      mSel = srcSel ? mAlt : mSnap;
      mGo = trigger && (!chgDetEn || !mPrevValid || (mSel != mPrev));
      if (pinLatch) mSnap <= pinIn;
      if (altWrEn) mAlt <= altWrData;
      eStart <= mGo;
      if (mGo) begin
        mPrev <= mSel;
        mPrevValid <= 1'b1;
        eData <= mSel;
        eLen <= int'(baseSize) + 1 + (ext4 ? 16 : 0) + ((ext5 && mode64En) ? 32 : 0);
      end
      eCs <= contCsEn && !tsbEn;
      eErr <= chgDetEn && contCsEn;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tagStart);
    check(tagStart, frameStart, eStart);
    check("R2 frameData", frameData, eData);
    check("R6 frameLen", frameLen, eLen);
    check("R8 csHold", csHold, eCs);
    check("R9 cfgErr", cfgErr, eErr);
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    compareAll(chgDetEn ? "R4 frameStart" : "R3 frameStart");
  endtask

  task automatic idle();
    trigger = 0; pinLatch = 0; altWrEn = 0;
  endtask

  initial begin
    rstN = 0; idle(); pinIn = '0; altWrData = '0; srcSel = 0; chgDetEn = 0;
    contCsEn = 0; tsbEn = 0; mode64En = 0; baseSize = '0; ext4 = 0; ext5 = 0;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    check("R10 frameStart", frameStart, 0);
    check("R10 frameData", frameData, 0);
    check("R10 frameLen", frameLen, 0);
    check("R10 csHold", csHold, 0);
    check("R10 cfgErr", cfgErr, 0);
    rstN = 1;

    // R1: latch pins, then trigger from snapshot
    pinIn = 8'hA5; pinLatch = 1; step();
    idle(); pinIn = 8'h11; trigger = 1; baseSize = 4'd7; ext4 = 1; step();
    check("R1 snapshot data", frameData, 8'hA5);
    check("R6 len 24", frameLen, 24);
    // R2: alternate source
    idle(); altWrData = 8'h3C; altWrEn = 1; step();
    idle(); srcSel = 1; trigger = 1; step();
    check("R2 alt data", frameData, 8'h3C);
    // R7: ext5 without 64-bit mode
    idle(); trigger = 1; baseSize = 4'd15; ext4 = 1; ext5 = 1; mode64En = 0; step();
    check("R7 len capped", frameLen, 32);
    idle(); trigger = 1; mode64En = 1; step();
    check("R6 len 64", frameLen, 64);
    // R4/R5: change detect, same word suppressed
    idle(); chgDetEn = 1; trigger = 1; step();
    check("R4 suppressed", frameStart, 0);
    idle(); altWrData = 8'h77; altWrEn = 1; step();
    idle(); altWrData = 8'h3C; altWrEn = 1; step();
    idle(); trigger = 1; step();
    check("R5 prev unchanged", frameStart, 0);
    idle(); altWrData = 8'h42; altWrEn = 1; step();
    idle(); trigger = 1; step();
    check("R4 changed starts", frameStart, 1);
    check("R4 changed data", frameData, 8'h42);
    // R8/R9
    idle(); contCsEn = 1; tsbEn = 1; step();
    check("R8 tsb blocks hold", csHold, 0);
    check("R9 conflict", cfgErr, 1);
    chgDetEn = 0; tsbEn = 0; step();
    check("R8 hold", csHold, 1);
    check("R9 clear", cfgErr, 0);

    // randomized phase
    for (int i = 0; i < 600; i++) begin
      trigger = ($urandom % 3) != 0;
      pinLatch = $urandom % 2;
      altWrEn = ($urandom % 4) == 0;
      pinIn = DW'($urandom % 4);
      altWrData = DW'($urandom % 4);
      srcSel = $urandom % 2;
      chgDetEn = ($urandom % 3) != 0;
      contCsEn = $urandom % 2;
      tsbEn = ($urandom % 4) == 0;
      mode64En = $urandom % 2;
      baseSize = BW'($urandom);
      ext4 = $urandom % 2;
      ext5 = $urandom % 2;
      if (i == 300) rstN = 0;
      if (i == 302) rstN = 1;
      step();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule